// File: doc/BRIEF.md
# Digital Dual-Mixer Time-Difference Meter

This block compares the timing of two oscillators that run at the same nominal carrier. It takes two sample streams at the same rate, one from a reference oscillator and one from a device under test. Both streams are multiplied by one shared numerically controlled oscillator, which is tuned slightly away from the carrier. Each channel then carries a slow beat note. Each beat note passes through a two-section low-pass filter and a zero-crossing detector with hysteresis.

Each rising crossing is stamped by a free-running sample counter. For every device crossing that follows a reference crossing, the block emits one signed word: the sample interval between the two crossings. The phase difference between the oscillators is stretched by the ratio of carrier to offset. At a 10 MHz carrier, one count corresponds to 1e-6 of real time difference at a 10 Hz offset, and to 1e-7 at a 1 Hz offset.

The words leave through a valid/ready handshake towards a host, which computes the stability statistics.

Top module: `dmtd_meter`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `diff_valid` and `drop_pulse` are both low.
- R2: The oscillator phase grows by `tune_word` on every sample. The oscillator output is the cosine of the upper phase bits, built from a quarter-wave amplitude map with 10 address bits. With `tune_word` = 0 it sits at positive full scale, so each mixer product has the sign of its input sample, and a zero input gives a zero product.
- R3: Each channel filters its product through two cascaded first-order sections. Each section computes y <= y + ((in - y) >>> `lp_shift`) at full product precision. With `lp_shift` = 0 each section is a one-sample delay. Both channels are filtered the same way.
- R4: A rising crossing is one event. It fires after at least HOLD (4) consecutive negative filtered samples, followed by HOLD consecutive non-negative samples. A zero sample counts as non-negative.
- R5: A run of opposite sign shorter than HOLD samples, inside a negative or a non-negative stretch, creates no crossing.
- R6: `diff_data` is a 48-bit two's-complement value. It equals the sample index of a device crossing minus the sample index of the newest reference crossing at or before it. Crossings on the same sample give 0.
- R7: A reference crossing that arrives while an earlier one is still unpaired raises `drop_pulse` for one cycle. The earlier crossing is discarded, and the newer one becomes the pending crossing.
- R8: A device crossing with no pending reference crossing produces no word and no `drop_pulse`.
- R9: While `diff_valid` is high and `diff_ready` is low, `diff_valid` stays high and `diff_data` does not change. A result that completes during that time is discarded with a one-cycle `drop_pulse`.
- R10: With equal constant inputs and a nonzero tuning word, every word after the first is 0. With inputs of opposite sign, every word after the first is half the oscillator period (2^32 / `tune_word` samples), within 2 samples.
- R11: The timestamp counter is 48 bits wide and advances by one on every sample after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one sample per channel per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_smp | input | 12 | Signed reference oscillator sample |
| dut_smp | input | 12 | Signed device-under-test sample |
| tune_word | input | 32 | Phase increment of the shared offset oscillator |
| lp_shift | input | 4 | Shift coefficient of both filter sections |
| diff_data | output | 48 | Signed crossing interval in samples |
| diff_valid | output | 1 | `diff_data` holds an unread result |
| diff_ready | input | 1 | Consumer accepts the result |
| drop_pulse | output | 1 | One-cycle pulse when a measurement or a result is discarded |

## Verification
The hardest thing to reach from the ports is exact, sample-by-sample control of where crossings fall in each channel, because the oscillator and two filter sections stand between the inputs and the detectors. The stimulus sets the tuning word and the shift to zero. The oscillator then holds at full scale and each filter becomes a pure delay, so the signs of the driven samples are exactly the signs the detectors see. Sweeps of channel offset, chatter length, crossing rate and crossings that arrive before any reference can then be compared against an arithmetic model. Discarding a result while the output register is full is reached by holding `diff_ready` low across a run with several pairings. Separate runs with a live oscillator check the full mixer and filter path at two tunings and two shifts.

// File: rtl/dmtd_pkg.sv
package dmtd_pkg;
  localparam int CH_REF = 0;
  localparam int CH_DUT = 1;
  localparam int NCH    = 2;

  // Quarter-wave amplitude for address a in [0, 2^aw]: parabolic approximation
  // of a rising sine, reaching amp exactly at a = 2^aw.
  function automatic int qwave(int unsigned a, int aw, int amp);
    longint prod;
    prod = longint'(a) * (longint'(2) * (longint'(1) << aw) - longint'(a)) * longint'(amp);
    return int'(prod >>> (2 * aw));
  endfunction

  // Cosine from quadrant q and in-quadrant address a.
  function automatic int cos_of(int unsigned q, int unsigned a, int aw, int amp);
    int unsigned n;
    n = 32'd1 << aw;
    case (q)
      0: return  qwave(n - a, aw, amp);
      1: return -qwave(a, aw, amp);
      2: return -qwave(n - a, aw, amp);
      default: return qwave(a, aw, amp);
    endcase
  endfunction

  // One first-order shift section step.
  function automatic longint lp_next(longint y, longint x, int k);
    return y + ((x - y) >>> k);
  endfunction
endpackage

// File: rtl/dmtd_nco.sv
module dmtd_nco #(
  parameter int PW = 32,
  parameter int AW = 10,
  parameter int LW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PW-1:0]        tune,
  output logic signed [LW-1:0] lo
);
  import dmtd_pkg::*;
  localparam int AMP = 2 ** (LW - 1) - 1;

  logic [PW-1:0] phase_q;
  int            lo_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_q + tune;
  end

  always_comb begin
    lo_i = cos_of(32'(phase_q[PW-1 -: 2]), 32'(phase_q[PW-3 -: AW]), AW, AMP);
  end

  assign lo = lo_i[LW-1:0];
endmodule

// File: rtl/dmtd_lowpass.sv
module dmtd_lowpass #(
  parameter int MW   = 24,
  parameter int NSEC = 2,
  parameter int SW   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [MW-1:0] x,
  input  logic [SW-1:0]        k,
  output logic signed [MW-1:0] y
);
  import dmtd_pkg::*;

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    logic signed [MW-1:0] din;
    logic signed [MW-1:0] q;
    longint               nx;
    if (s == 0) begin : g_first
      assign din = x;
    end else begin : g_next
      assign din = g_sec[s-1].q;
    end
    always_comb nx = lp_next(longint'(q), longint'(din), int'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nx[MW-1:0];
    end
  end

  assign y = g_sec[NSEC-1].q;
endmodule

// File: rtl/dmtd_xdetect.sv
module dmtd_xdetect #(
  parameter int MW   = 24,
  parameter int HOLD = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [MW-1:0] y,
  output logic                 neg,
  output logic                 hit
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HV = CW'(HOLD);

  logic [CW-1:0] nc_q, pc_q;
  logic          armed_q;

  assign neg = y[MW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nc_q <= '0; pc_q <= '0; armed_q <= 1'b0; hit <= 1'b0;
    end else if (neg) begin
      hit  <= 1'b0;
      pc_q <= '0;
      if (nc_q != HV) nc_q <= nc_q + 1'b1;
      if (nc_q >= HV - 1'b1) armed_q <= 1'b1;
    end else begin
      nc_q <= '0;
      if (armed_q && pc_q == HV - 1'b1) begin
        hit <= 1'b1; armed_q <= 1'b0; pc_q <= '0;
      end else begin
        hit  <= 1'b0;
        pc_q <= armed_q ? pc_q + 1'b1 : '0;
      end
    end
  end
endmodule

// File: rtl/dmtd_pair.sv
module dmtd_pair #(
  parameter int TW = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hit_ref,
  input  logic                 hit_dut,
  input  logic [TW-1:0]        stamp,
  input  logic                 diff_ready,
  output logic signed [TW-1:0] diff_data,
  output logic                 diff_valid,
  output logic                 drop_pulse,
  output logic                 pend
);
  logic [TW-1:0] ref_ts_q, base, dval;
  logic          fire, held;

  assign fire = hit_dut && (pend || hit_ref);
  assign held = diff_valid && !diff_ready;
  assign base = hit_ref ? stamp : ref_ts_q;
  assign dval = stamp - base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; ref_ts_q <= '0; drop_pulse <= 1'b0;
      diff_valid <= 1'b0; diff_data <= '0;
    end else begin
      if (hit_dut)      pend <= 1'b0;
      else if (hit_ref) pend <= 1'b1;
      if (hit_ref) ref_ts_q <= stamp;
      drop_pulse <= (hit_ref && pend) || (fire && held);
      if (fire && !held) begin
        diff_valid <= 1'b1;
        diff_data  <= dval;
      end else if (diff_ready) begin
        diff_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dmtd_meter.sv
module dmtd_meter #(
  parameter int XW   = 12,
  parameter int LW   = 12,
  parameter int PW   = 32,
  parameter int AW   = 10,
  parameter int SW   = 4,
  parameter int NSEC = 2,
  parameter int HOLD = 4,
  parameter int TW   = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [XW-1:0] ref_smp,
  input  logic signed [XW-1:0] dut_smp,
  input  logic [PW-1:0]        tune_word,
  input  logic [SW-1:0]        lp_shift,
  output logic signed [TW-1:0] diff_data,
  output logic                 diff_valid,
  input  logic                 diff_ready,
  output logic                 drop_pulse
);
  import dmtd_pkg::*;
  localparam int MW = XW + LW;

  logic signed [LW-1:0] lo;
  logic [NCH-1:0]       hit_w, neg_w;
  logic                 pend_w;
  logic [TW-1:0]        stamp_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stamp_w <= '0;
    else        stamp_w <= stamp_w + 1'b1;
  end

  dmtd_nco #(.PW(PW), .AW(AW), .LW(LW)) nco_i (
    .clk(clk), .rst_n(rst_n), .tune(tune_word), .lo(lo));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [XW-1:0] s_in;
    logic signed [MW-1:0] mix_q, filt;
    if (c == CH_REF) begin : g_ref
      assign s_in = ref_smp;
    end else begin : g_dut
      assign s_in = dut_smp;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mix_q <= '0;
      else        mix_q <= s_in * lo;
    end
    dmtd_lowpass #(.MW(MW), .NSEC(NSEC), .SW(SW)) lp_i (
      .clk(clk), .rst_n(rst_n), .x(mix_q), .k(lp_shift), .y(filt));
    dmtd_xdetect #(.MW(MW), .HOLD(HOLD)) xd_i (
      .clk(clk), .rst_n(rst_n), .y(filt), .neg(neg_w[c]), .hit(hit_w[c]));
  end

  dmtd_pair #(.TW(TW)) pair_i (
    .clk(clk), .rst_n(rst_n), .hit_ref(hit_w[CH_REF]), .hit_dut(hit_w[CH_DUT]),
    .stamp(stamp_w), .diff_ready(diff_ready), .diff_data(diff_data),
    .diff_valid(diff_valid), .drop_pulse(drop_pulse), .pend(pend_w));
endmodule

// File: rtl/dmtd_meter_chk.sv
module dmtd_meter_chk #(
  parameter int TW = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    hit_w,
  input logic [1:0]    neg_w,
  input logic          pend_w,
  input logic [TW-1:0] stamp_w,
  input logic          diff_valid,
  input logic          diff_ready,
  input logic [TW-1:0] diff_data,
  input logic          drop_pulse
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!diff_valid && !drop_pulse));

  assert_ref_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_w[0] |-> !$past(neg_w[0]));

  assert_dut_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_w[1] |-> !$past(neg_w[1]));

  assert_no_rehit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_w[0] |=> !hit_w[0]);

  assert_result_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_w[1] && (pend_w || hit_w[0]) && !(diff_valid && !diff_ready)) |=> diff_valid);

  assert_overrun_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_w[0] && pend_w) |=> drop_pulse);

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (diff_valid && !diff_ready) |=> (diff_valid && $stable(diff_data)));

  assert_stamp_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (stamp_w == $past(stamp_w) + 1'b1));
endmodule

bind dmtd_meter dmtd_meter_chk #(.TW(TW)) chk_i (
  .clk(clk), .rst_n(rst_n), .hit_w(hit_w), .neg_w(neg_w), .pend_w(pend_w),
  .stamp_w(stamp_w), .diff_valid(diff_valid), .diff_ready(diff_ready),
  .diff_data(diff_data), .drop_pulse(drop_pulse));

// File: tb/dmtd_meter_tb_top.sv
module dmtd_meter_tb_top;
  localparam int XW = 12, PW = 32, SW = 4, TW = 48, H = 4, MAXS = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic signed [XW-1:0] ref_smp = '0, dut_smp = '0;
  logic [PW-1:0] tune_word = '0;
  logic [SW-1:0] lp_shift = '0;
  logic signed [TW-1:0] diff_data;
  logic diff_valid, diff_ready = 1'b1, drop_pulse;

  always #10 clk = ~clk;

  dmtd_meter dut_i (
    .clk(clk), .rst_n(rst_n), .ref_smp(ref_smp), .dut_smp(dut_smp),
    .tune_word(tune_word), .lp_shift(lp_shift), .diff_data(diff_data),
    .diff_valid(diff_valid), .diff_ready(diff_ready), .drop_pulse(drop_pulse));

  int n_vec = 0, n_bad = 0;
  int rv[MAXS], dv[MAXS];
  int n_smp;
  longint expd[64];
  int n_exp, exp_drop;
  longint got[256];
  int n_got, n_drop;
  bit done = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (diff_valid && diff_ready && n_got < 256) begin
        got[n_got] = longint'(diff_data);
        n_got++;
      end
      if (drop_pulse) n_drop++;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; ref_smp = '0; dut_smp = '0;
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    n_got = 0; n_drop = 0;
  endtask

  function automatic int sq(input int i, input int off, input int nl, input int pl);
    int per, p;
    per = nl + pl;
    p = (((i - off) % per) + per) % per;
    if (p < nl) return -(300 + p * 7);
    return (p % 3 == 0) ? 0 : (250 + p);
  endfunction

  // Reference model: crossing rules and pairing rules applied per sample index.
  task automatic model();
    int nc[2], pc[2];
    bit arm[2], hit[2], pend;
    int ref_i;
    nc = '{0, 0}; pc = '{0, 0}; arm = '{0, 0}; pend = 0; ref_i = 0;
    n_exp = 0; exp_drop = 0;
    for (int i = 0; i < n_smp; i++) begin
      for (int ch = 0; ch < 2; ch++) begin
        int v;
        v = (ch == 1) ? dv[i] : rv[i];
        hit[ch] = 0;
        if (v < 0) begin
          pc[ch] = 0;
          if (nc[ch] >= H - 1) arm[ch] = 1;
          if (nc[ch] < H) nc[ch]++;
        end else begin
          nc[ch] = 0;
          if (arm[ch] && pc[ch] == H - 1) begin
            hit[ch] = 1; arm[ch] = 0; pc[ch] = 0;
          end else pc[ch] = arm[ch] ? pc[ch] + 1 : 0;
        end
      end
      if (hit[0] && pend) exp_drop++;
      if (hit[1]) begin
        if (hit[0] && n_exp < 64) begin expd[n_exp] = 0; n_exp++; end
        else if (pend && n_exp < 64) begin expd[n_exp] = longint'(i - ref_i); n_exp++; end
        pend = 0;
      end else if (hit[0]) begin
        pend = 1; ref_i = i;
      end
    end
  endtask

  task automatic play();
    for (int i = 0; i < n_smp; i++) begin
      ref_smp = rv[i][XW-1:0];
      dut_smp = dv[i][XW-1:0];
      @(posedge clk); #1;
    end
    ref_smp = '0; dut_smp = '0;
    repeat (40) @(posedge clk);
    #1;
  endtask

  task automatic add_tail();
    for (int i = n_smp - 8; i < n_smp; i++) begin rv[i] = 0; dv[i] = 0; end
  endtask

  task automatic run_pattern(input string req);
    model();
    do_reset();
    play();
    check(n_got == n_exp, {req, " word count"}, n_got, n_exp);
    for (int j = 0; j < n_exp && j < n_got; j++)
      check(got[j] == expd[j], {req, " interval"}, got[j], expd[j]);
    check(n_drop == exp_drop, {req, " drop count"}, n_drop, exp_drop);
  endtask

  task automatic nco_run(input longint tw, input int k, input int dsign);
    longint half;
    half = (longint'(1) << 32) / tw / 2;
    tune_word = tw[PW-1:0];
    lp_shift = k[SW-1:0];
    do_reset();
    ref_smp = 12'sd1000;
    dut_smp = (dsign > 0) ? 12'sd1000 : -12'sd1000;
    repeat (3000) @(posedge clk);
    #1;
    check(n_got >= 5, "R10 word count", n_got, 5);
    check(n_drop == 0, "R3 R10 drops", n_drop, 0);
    for (int j = 1; j < n_got; j++) begin
      if (dsign > 0) check(got[j] == 0, "R2 R3 R10 equal inputs", got[j], 0);
      else check(got[j] >= half - 2 && got[j] <= half + 2, "R2 R3 R10 half period", got[j], half);
    end
  endtask

  initial begin
    // R1: quiet reset
    do_reset();
    check(diff_valid == 1'b0 && drop_pulse == 1'b0, "R1 reset", {diff_valid, drop_pulse}, 0);
    repeat (5) begin
      @(negedge clk);
      check(diff_valid == 1'b0 && drop_pulse == 1'b0, "R1 idle", {diff_valid, drop_pulse}, 0);
    end

    // R2 R4 R6 R11: channel offset sweep with DC oscillator and delay filters
    tune_word = '0; lp_shift = '0;
    n_smp = 160;
    for (int off = 0; off < 16; off++) begin
      for (int i = 0; i < n_smp; i++) begin rv[i] = sq(i, 0, 8, 8); dv[i] = sq(i, off, 8, 8); end
      add_tail();
      run_pattern("R2 R4 R6 R11");
    end

    // R5: chatter shorter than, then equal to, the hold count
    n_smp = 200;
    for (int cl = 1; cl <= H; cl++) begin
      for (int i = 0; i < n_smp; i++) begin
        int p;
        p = i % 24;
        rv[i] = sq(i, 0, 12, 12);
        if (p >= 4 && p < 4 + cl) rv[i] = 250;
        if (p >= 16 && p < 16 + cl) rv[i] = -300;
        dv[i] = sq(i, 3, 12, 12);
      end
      add_tail();
      run_pattern("R4 R5");
    end

    // R7: reference crosses faster than the device
    n_smp = 240;
    for (int i = 0; i < n_smp; i++) begin rv[i] = sq(i, 0, 5, 5); dv[i] = sq(i, 2, 15, 15); end
    add_tail();
    run_pattern("R7");
    for (int i = 0; i < n_smp; i++) begin rv[i] = sq(i, 0, 5, 5); dv[i] = sq(i, 0, 10, 10); end
    add_tail();
    run_pattern("R6 R7 same sample");

    // R8: device crossings before any reference crossing
    for (int i = 0; i < n_smp; i++) begin
      rv[i] = (i < 80) ? 250 : sq(i, 0, 6, 6);
      dv[i] = sq(i, 3, 6, 6);
    end
    add_tail();
    run_pattern("R8");
    for (int i = 0; i < n_smp; i++) begin rv[i] = 250; dv[i] = sq(i, 0, 6, 6); end
    add_tail();
    run_pattern("R8 no reference");

    // R9: output held while the consumer stalls
    n_smp = 160;
    for (int i = 0; i < n_smp; i++) begin rv[i] = sq(i, 0, 8, 8); dv[i] = sq(i, 5, 8, 8); end
    add_tail();
    model();
    do_reset();
    diff_ready = 1'b0;
    play();
    @(negedge clk);
    check(diff_valid == 1'b1, "R9 held valid", diff_valid, 1);
    check(longint'(diff_data) == expd[0], "R9 held data", longint'(diff_data), expd[0]);
    check(n_drop == exp_drop + n_exp - 1, "R9 discarded results", n_drop, exp_drop + n_exp - 1);
    repeat (3) @(negedge clk);
    check(longint'(diff_data) == expd[0], "R9 data stable", longint'(diff_data), expd[0]);
    @(posedge clk); #1;
    diff_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(n_got == 1, "R9 single transfer", n_got, 1);
    check(got[0] == expd[0], "R9 transferred word", got[0], expd[0]);
    check(diff_valid == 1'b0, "R9 valid clears", diff_valid, 0);

    // R2 R3 R10: live oscillator through the full filter path
    for (int t = 0; t < 2; t++) begin
      for (int kk = 0; kk < 2; kk++) begin
        nco_run(longint'(1) << (24 + t), (kk == 0) ? 2 : 5, 1);
        nco_run(longint'(1) << (24 + t), (kk == 0) ? 2 : 5, -1);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL R1 watchdog: actual %0d cycles expected fewer than %0d", 150000, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule